// File: doc/BRIEF.md
# UART Line Path and Flow-Resume Controller

This block sits between a UART's transmitter and receiver and the two serial pins. It steers the serial streams along one of three paths: a plain wire path, an internal loopback in which the transmitter feeds the receiver, or an infrared pulse path. On the infrared path, each transmitted zero becomes a short high pulse and received pulses are stretched back into zero bits. The receive level going to the infrared decoder can be inverted for optical modules whose output is active low.

The infrared selection is loaded from a strap pin whenever a hardware or soft reset occurs, and software can overwrite it afterwards. A prescaler placed ahead of the baud generator either passes each raw tick through or keeps one tick in four. It is built as a clock enable, and a new divide selection takes effect only when the tick counter wraps. A transmit-halt flag is set by an external "stop character seen" strobe and cleared by a "resume character seen" strobe. When the any-character-resumes option is on, any received character also clears it.

Top module: `uart_line_ctl`

## Requirements
- R1: `ir_mode` takes the level of `strap_ir` at every cycle with `rst` or `soft_rst` high. Otherwise a cycle with `ir_wr` high loads `ir_wdata` into it. When `soft_rst` and `ir_wr` are both high, `soft_rst` wins.
- R2: While in reset, the registered outputs are: `ir_mode` = `strap_ir`, `tx_pin` = NOT `strap_ir` (the idle level of that mode), `rx_to_rcv` = 1, `baud_en` = 0, `tx_halt` = 0.
- R3: On the wire path (`loop_en`=0, `ir_mode`=0), `tx_pin` copies `tx_ser` and `rx_to_rcv` copies `rx_pin`, each one cycle later.
- R4: With `loop_en`=1, `rx_to_rcv` copies `tx_ser` one cycle later and ignores `rx_pin`. `tx_pin` is held at the idle level: 1 when `ir_mode`=0 and 0 when `ir_mode`=1.
- R5: On the infrared path, a `tx_bit_strobe` cycle latches `tx_ser` as the current bit. For a 0 bit, `tx_pin` is high from the second cycle after the strobe for PULSE_TICKS sample ticks of each OVS-tick bit period. For a 1 bit, `tx_pin` stays 0. The idle output is 0.
- R6: On the infrared path, a high level at the decoder input drives `rx_to_rcv` to 0 two cycles later. It stays 0 until OVS sample ticks have passed with the input low, and is 1 otherwise.
- R7: The decoder input is `rx_pin` XOR `ir_rx_inv`. With `ir_rx_inv`=1, a low `rx_pin` counts as a pulse and a high `rx_pin` counts as idle.
- R8: With the divide-by-one selection active, each cycle with `tick_in` high gives `baud_en` high on the next cycle, and no other cycle does.
- R9: With divide-by-four active, only every fourth `tick_in` gives `baud_en`: the fourth, eighth, and so on, counted from reset. `pre_div4` is read at reset and at each fourth tick, and applies from the following tick on.
- R10: `xoff_seen` sets `tx_halt` on the next cycle, and `xon_seen` clears it.
- R11: `rx_char` clears `tx_halt` only when `xon_any_en`=1. With `xon_any_en`=0 it has no effect on `tx_halt`.
- R12: When `xoff_seen` is high in the same cycle as `xon_seen`, or as `rx_char` with `xon_any_en`=1, `tx_halt` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Soft reset; reloads the infrared selection from the strap |
| strap_ir | input | 1 | Strap level giving the default infrared selection |
| ir_wr | input | 1 | Software write strobe for the infrared selection |
| ir_wdata | input | 1 | Value written to the infrared selection |
| loop_en | input | 1 | Internal loopback enable |
| xon_any_en | input | 1 | Any received character clears the halt |
| ir_rx_inv | input | 1 | Invert receive level ahead of the infrared decoder |
| pre_div4 | input | 1 | Prescaler select: 0 divide by one, 1 divide by four |
| tick_in | input | 1 | Raw tick source for the baud generator |
| samp_tick | input | 1 | Oversample tick (OVS per bit) for infrared timing |
| rx_pin | input | 1 | External serial receive pin |
| tx_ser | input | 1 | Transmitter serial output |
| tx_bit_strobe | input | 1 | Transmitter starts a new bit |
| rx_char | input | 1 | Receiver has completed a character |
| xoff_seen | input | 1 | Stop character detected |
| xon_seen | input | 1 | Resume character detected |
| tx_pin | output | 1 | Routed serial transmit pin |
| rx_to_rcv | output | 1 | Routed serial input to the receiver |
| baud_en | output | 1 | Prescaled clock enable for the baud generator |
| tx_halt | output | 1 | Transmission halted by flow control |
| ir_mode | output | 1 | Current infrared selection |

## Verification
The bench builds the block with its defaults, OVS=16, PULSE_TICKS=3 and PRE_DIV=4, and holds `samp_tick` high. A bit period is therefore sixteen cycles, so the whole three-tick pulse, its wrap into the next period and the decoder's sixteen-tick stretch all end inside a few dozen cycles. The bench keeps its own count of raw ticks, which makes the divide-by-four pattern and a select change made between two wraps, in each direction, predictable from the ports alone.

// File: rtl/ulc_pkg.sv
package ulc_pkg;
  typedef enum logic [1:0] {
    PATH_WIRE = 2'd0,
    PATH_LOOP = 2'd1,
    PATH_IR   = 2'd2
  } path_e;

  // idle level of the transmit pin for a given infrared selection
  function automatic logic idle_level(input logic ir);
    return ~ir;
  endfunction
endpackage

// File: rtl/ulc_prescale.sv
module ulc_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_div,
  input  logic tick_in,
  output logic tick_out
);
  generate
    if (DIV < 2) begin : g_pass
      always_ff @(posedge clk) begin
        if (rst) tick_out <= 1'b0;
        else     tick_out <= tick_in;
      end
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;
      logic          sel_q;
      logic          wrap;

      assign wrap = tick_in && (cnt == LAST);

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt      <= '0;
          sel_q    <= sel_div;
          tick_out <= 1'b0;
        end else begin
          tick_out <= tick_in && (!sel_q || cnt == LAST);
          if (tick_in) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
          if (wrap)    sel_q <= sel_div;
        end
      end
    end
  endgenerate

  AST_EN_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    tick_out |-> $past(tick_in)); // R8
endmodule

// File: rtl/ulc_ir_enc.sv
module ulc_ir_enc #(
  parameter int OVS         = 16,
  parameter int PULSE_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic samp_tick,
  input  logic bit_strobe,
  input  logic bit_in,
  output logic pulse
);
  localparam int PW = $clog2(OVS);
  localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);
  localparam logic [PW-1:0] PH_ON   = PW'(PULSE_TICKS);

  logic [PW-1:0] ph;
  logic          bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= '0;
      bit_q <= 1'b1;
    end else if (bit_strobe) begin
      ph    <= '0;
      bit_q <= bit_in;
    end else if (samp_tick) begin
      ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
    end
  end

  assign pulse = !bit_q && (ph < PH_ON);

  AST_ENC_ZERO_LIGHTS: assert property (@(posedge clk) disable iff (rst)
    (bit_strobe && !bit_in) |=> pulse); // R5
endmodule

// File: rtl/ulc_ir_dec.sv
module ulc_ir_dec #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic samp_tick,
  input  logic din,
  output logic bit_out
);
  localparam int CW = $clog2(OVS + 1);
  localparam logic [CW-1:0] HOLD = CW'(OVS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                          cnt <= '0;
    else if (din)                     cnt <= HOLD;
    else if (samp_tick && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign bit_out = (cnt == '0);

  AST_DEC_PULSE_ZERO: assert property (@(posedge clk) disable iff (rst)
    din |=> !bit_out); // R6
endmodule

// File: rtl/uart_line_ctl.sv
module uart_line_ctl
  import ulc_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int PULSE_TICKS = 3,
  parameter int PRE_DIV     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic soft_rst,
  input  logic strap_ir,
  input  logic ir_wr,
  input  logic ir_wdata,
  input  logic loop_en,
  input  logic xon_any_en,
  input  logic ir_rx_inv,
  input  logic pre_div4,
  input  logic tick_in,
  input  logic samp_tick,
  input  logic rx_pin,
  input  logic tx_ser,
  input  logic tx_bit_strobe,
  input  logic rx_char,
  input  logic xoff_seen,
  input  logic xon_seen,
  output logic tx_pin,
  output logic rx_to_rcv,
  output logic baud_en,
  output logic tx_halt,
  output logic ir_mode
);
  logic  ir_en;
  logic  enc_pulse;
  logic  dec_bit;
  logic  dec_in;
  logic  resume;
  path_e path;

  // infrared selection: strap on any reset, software afterwards
  always_ff @(posedge clk) begin
    if (rst || soft_rst) ir_en <= strap_ir;
    else if (ir_wr)      ir_en <= ir_wdata;
  end
  assign ir_mode = ir_en;

  always_comb begin
    if (loop_en)    path = PATH_LOOP;
    else if (ir_en) path = PATH_IR;
    else            path = PATH_WIRE;
  end

  assign dec_in = rx_pin ^ ir_rx_inv;

  ulc_ir_enc #(.OVS(OVS), .PULSE_TICKS(PULSE_TICKS)) u_enc (
    .clk(clk), .rst(rst), .samp_tick(samp_tick),
    .bit_strobe(tx_bit_strobe), .bit_in(tx_ser), .pulse(enc_pulse)
  );

  ulc_ir_dec #(.OVS(OVS)) u_dec (
    .clk(clk), .rst(rst), .samp_tick(samp_tick),
    .din(dec_in), .bit_out(dec_bit)
  );

  ulc_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .sel_div(pre_div4),
    .tick_in(tick_in), .tick_out(baud_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pin    <= idle_level(strap_ir);
      rx_to_rcv <= 1'b1;
    end else begin
      case (path)
        PATH_LOOP: begin
          tx_pin    <= idle_level(ir_en);
          rx_to_rcv <= tx_ser;
        end
        PATH_IR: begin
          tx_pin    <= enc_pulse;
          rx_to_rcv <= dec_bit;
        end
        default: begin
          tx_pin    <= tx_ser;
          rx_to_rcv <= rx_pin;
        end
      endcase
    end
  end

  // flow-control halt: a stop character outranks any resume
  assign resume = xon_seen || (xon_any_en && rx_char);

  always_ff @(posedge clk) begin
    if (rst)            tx_halt <= 1'b0;
    else if (xoff_seen) tx_halt <= 1'b1;
    else if (resume)    tx_halt <= 1'b0;
  end

  AST_SOFT_RELOAD: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> ir_mode == $past(strap_ir)); // R1
  AST_LOOP_TX_IDLE: assert property (@(posedge clk) disable iff (rst)
    loop_en |=> tx_pin == !$past(ir_mode)); // R4
  AST_HALT_SET: assert property (@(posedge clk) disable iff (rst)
    xoff_seen |=> tx_halt); // R12
  AST_ANY_RESUME: assert property (@(posedge clk) disable iff (rst)
    (xon_any_en && rx_char && !xoff_seen) |=> !tx_halt); // R11
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!xon_seen && !xoff_seen && !(xon_any_en && rx_char)) |=> $stable(tx_halt)); // R10
endmodule

// File: tb/tb_uart_line_ctl.sv
module tb_uart_line_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic soft_rst = 0, strap_ir = 1, ir_wr = 0, ir_wdata = 0, loop_en = 0;
  logic xon_any_en = 0, ir_rx_inv = 0, pre_div4 = 0, tick_in = 0;
  logic samp_tick = 1, rx_pin = 1, tx_ser = 1, tx_bit_strobe = 0;
  logic rx_char = 0, xoff_seen = 0, xon_seen = 0;
  logic tx_pin, rx_to_rcv, baud_en, tx_halt, ir_mode;

  always #2 clk = ~clk;

  uart_line_ctl dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .strap_ir(strap_ir),
    .ir_wr(ir_wr), .ir_wdata(ir_wdata), .loop_en(loop_en),
    .xon_any_en(xon_any_en), .ir_rx_inv(ir_rx_inv), .pre_div4(pre_div4),
    .tick_in(tick_in), .samp_tick(samp_tick), .rx_pin(rx_pin),
    .tx_ser(tx_ser), .tx_bit_strobe(tx_bit_strobe), .rx_char(rx_char),
    .xoff_seen(xoff_seen), .xon_seen(xon_seen), .tx_pin(tx_pin),
    .rx_to_rcv(rx_to_rcv), .baud_en(baud_en), .tx_halt(tx_halt),
    .ir_mode(ir_mode)
  );

  typedef struct {
    int    due;
    int    sig;
    logic  val;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, n_run = 0, n_fail = 0;
  bit done = 0;
  int nt = 0;
  logic sel_m = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // sig: 0 tx_pin, 1 rx_to_rcv, 2 baud_en, 3 tx_halt, 4 ir_mode
  task automatic expect_at(input int d, input int sig, input logic v, input string tag);
    exp_t e;
    e.due = cyc + d; e.sig = sig; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  function automatic logic pick(input int sig);
    case (sig)
      0: return tx_pin;
      1: return rx_to_rcv;
      2: return baud_en;
      3: return tx_halt;
      default: return ir_mode;
    endcase
  endfunction

  // monitor: compares every due item half a cycle after the edge
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        n_run++;
        if (pick(q[i].sig) !== q[i].val) begin
          n_fail++;
          $display("FAIL %s sig%0d cycle %0d: actual %b expected %b",
                   q[i].tag, q[i].sig, cyc, pick(q[i].sig), q[i].val);
        end
        q.delete(i);
      end
    end
  end

  // one raw tick; expected prescaler output from a bench-side count
  task automatic tick_once(input string tag);
    logic e;
    e = sel_m ? ((nt % 4) == 3) : 1'b1;
    if ((nt % 4) == 3) sel_m = pre_div4;
    nt++;
    tick_in = 1;
    expect_at(1, 2, e, tag);
    step();
    tick_in = 0;
    expect_at(1, 2, 1'b0, tag);
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired: actual hung expected finished");
    finish_run();
  end

  initial begin
    waitn(3);
    // R2 reset state with strap high
    expect_at(1, 4, 1'b1, "R2 ir_mode");
    expect_at(1, 0, 1'b0, "R2 tx_pin idle");
    expect_at(1, 1, 1'b1, "R2 rx_to_rcv");
    expect_at(1, 2, 1'b0, "R2 baud_en");
    expect_at(1, 3, 1'b0, "R2 tx_halt");
    step();
    rst = 0;
    step();
    // R1 software override, then soft reset beats a write
    ir_wr = 1; ir_wdata = 0;
    expect_at(1, 4, 1'b0, "R1 write");
    expect_at(2, 0, 1'b1, "R1 wire idle");
    step();
    soft_rst = 1; ir_wr = 1; ir_wdata = 0;
    expect_at(1, 4, 1'b1, "R1 soft beats write");
    step();
    soft_rst = 0; ir_wr = 0; strap_ir = 0;
    step();
    soft_rst = 1;
    expect_at(1, 4, 1'b0, "R1 soft reload");
    step();
    soft_rst = 0;
    step();
    // R3 wire path
    tx_ser = 0; rx_pin = 0;
    expect_at(1, 0, 1'b0, "R3 tx");
    expect_at(1, 1, 1'b0, "R3 rx");
    step();
    tx_ser = 1; rx_pin = 1;
    expect_at(1, 0, 1'b1, "R3 tx");
    expect_at(1, 1, 1'b1, "R3 rx");
    step();
    // R4 loopback
    loop_en = 1; tx_ser = 0; rx_pin = 1;
    expect_at(1, 1, 1'b0, "R4 loop rx");
    expect_at(1, 0, 1'b1, "R4 tx idle");
    step();
    tx_ser = 1; rx_pin = 0;
    expect_at(1, 1, 1'b1, "R4 rx_pin ignored");
    expect_at(1, 0, 1'b1, "R4 tx idle");
    step();
    ir_wr = 1; ir_wdata = 1;
    expect_at(2, 0, 1'b0, "R4 ir idle");
    step();
    ir_wr = 0;
    step();
    loop_en = 0; rx_pin = 0;
    waitn(20);
    // R5 encoder
    expect_at(1, 0, 1'b0, "R5 ir idle");
    expect_at(1, 1, 1'b1, "R6 no pulse");
    step();
    tx_bit_strobe = 1; tx_ser = 0;
    expect_at(1, 0, 1'b0, "R5 before");
    expect_at(2, 0, 1'b1, "R5 pulse start");
    expect_at(4, 0, 1'b1, "R5 pulse end");
    expect_at(5, 0, 1'b0, "R5 after pulse");
    expect_at(10, 0, 1'b0, "R5 dark");
    step();
    tx_bit_strobe = 0;
    waitn(5);
    tx_bit_strobe = 1; tx_ser = 1;
    expect_at(1, 0, 1'b0, "R5 one bit");
    expect_at(3, 0, 1'b0, "R5 one bit");
    expect_at(12, 0, 1'b0, "R5 one bit wrap");
    step();
    tx_bit_strobe = 0;
    waitn(20);
    // R6 decoder stretch
    rx_pin = 1;
    expect_at(1, 1, 1'b1, "R6 before");
    expect_at(2, 1, 1'b0, "R6 zero");
    expect_at(17, 1, 1'b0, "R6 held");
    expect_at(18, 1, 1'b1, "R6 release");
    step();
    rx_pin = 0;
    waitn(20);
    // R7 inversion
    ir_rx_inv = 1; rx_pin = 1;
    expect_at(1, 1, 1'b1, "R7 inverted idle");
    expect_at(3, 1, 1'b1, "R7 inverted idle");
    step();
    waitn(5);
    rx_pin = 0;
    expect_at(2, 1, 1'b0, "R7 inverted pulse");
    step();
    rx_pin = 1;
    waitn(20);
    ir_rx_inv = 0; rx_pin = 0;
    waitn(20);
    // R8 divide by one, R9 divide by four with changes between wraps
    for (int i = 0; i < 5; i++) tick_once("R8");
    pre_div4 = 1;
    for (int i = 0; i < 8; i++) tick_once("R9");
    pre_div4 = 0;
    for (int i = 0; i < 6; i++) tick_once("R9 back");
    // R10 R11 R12 halt
    xoff_seen = 1;
    expect_at(1, 3, 1'b1, "R10 set");
    step();
    xoff_seen = 0; rx_char = 1; xon_any_en = 0;
    expect_at(1, 3, 1'b1, "R11 char ignored");
    step();
    rx_char = 0; xon_seen = 1;
    expect_at(1, 3, 1'b0, "R10 clear");
    step();
    xon_seen = 0; xoff_seen = 1;
    step();
    xoff_seen = 0; xon_any_en = 1; rx_char = 1;
    expect_at(1, 3, 1'b0, "R11 any resumes");
    step();
    rx_char = 1; xoff_seen = 1;
    expect_at(1, 3, 1'b1, "R12 xoff over char");
    step();
    rx_char = 0; xoff_seen = 1; xon_seen = 1;
    expect_at(1, 3, 1'b1, "R12 xoff over xon");
    step();
    xoff_seen = 0;
    expect_at(1, 3, 1'b0, "R10 xon");
    step();
    xon_seen = 0;
    waitn(4);
    if (q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL pending checks: actual %0d expected 0", q.size());
    end
    finish_run();
  end
endmodule